// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is the arithmetic and logic stage of a small processor built around two 8-bit accumulators, A and B. It also has two 16-bit index registers, X and Y. It takes an operation select, the two accumulator values, both index values and a memory operand of up to 16 bits. From these it produces, in the same cycle, the result and a code that names the register that result belongs to. Fetch, decode, addressing and the register file sit outside the block: the surrounding core writes the result into the named register.

The block keeps the condition-code flags H (half carry), N (negative), Z (zero), V (overflow) and C (carry) in a register of its own. That register loads the new flags on a clock edge only while the execute strobe is high. The carry that add-with-carry consumes is the one currently held in that register. Each operation has its own rules for which flags it writes and which it keeps.

Top module: `acc_alu_cc`

## Requirements
- R1: Operation code 0 adds B to A. The 8-bit sum appears on `res[7:0]`, `dest` is 1 (A), and H, N, Z, V and C are all updated.
- R2: Operation codes 1 (into A) and 2 (into B) add the accumulator, `mem_op[7:0]` and the currently held C flag. Destination codes are 1 and 2. All five flags are updated.
- R3: Operation codes 3 (into A) and 4 (into B) add the accumulator and `mem_op[7:0]` with no carry-in. Destination codes are 1 and 2. All five flags are updated.
- R4: Operation codes 8 and 9 add B, zero-extended to 16 bits, to X (code 8, `dest` 4) or to Y (code 9, `dest` 5). The sum wraps modulo 2^16 and no flag changes.
- R5: Operation code 5 adds the 16-bit `mem_op` to the concatenation {A,B}, with A as the high byte. `dest` is 3 (double accumulator). N, Z, V and C are updated and H is kept.
- R6: Operation codes 6 (A) and 7 (B) form the bitwise AND of the accumulator with `mem_op[7:0]`. `dest` is 1 or 2. N and Z are updated, V is cleared, and H and C are kept.
- R7: Flag meaning. H is the carry from bit 3 into bit 4. C is the carry out of the top bit. V is set when both addends share a sign that differs from the sign of the result. N is the result's top bit. Z is set when the whole result, at the destination width, is zero.
- R8: Operation codes 10 to 15 are idle: `dest` is 0, `res` is 0 and no flag changes.
- R9: The flag register changes only on a rising clock edge with `exec_en` high. With `exec_en` low it holds its value whatever the operation.
- R10: While `rst_n` is low, all five flags read 0.
- R11: 8-bit results drive `res[15:8]` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| exec_en | input | 1 | Execute strobe; the flags load when it is high |
| op_sel | input | 4 | Operation code (see requirements) |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| idx_x | input | 16 | Index register X |
| idx_y | input | 16 | Index register Y |
| mem_op | input | 16 | Memory operand; 8-bit operations use the low byte |
| res | output | 16 | Result for the destination register |
| dest | output | 3 | Destination: 0 none, 1 A, 2 B, 3 D, 4 X, 5 Y |
| flag_h | output | 1 | Half-carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Two things can happen in the same cycle: an add-with-carry reads the held C, and the flag register is rewritten at that cycle's edge. The bench provokes this with back-to-back executed operations. An add with carry-out is followed at once by add-with-carry, and random streams hold `exec_en` high most of the time. The combinational result is judged mid-cycle against a model that uses the carry from before the edge. The flags are judged just after the edge against the model's updated state.

// File: rtl/acc_alu_cc.sv
module acc_alu_cc #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic [3:0]      op_sel,
  input  logic [DW-1:0]   acc_a,
  input  logic [DW-1:0]   acc_b,
  input  logic [2*DW-1:0] idx_x,
  input  logic [2*DW-1:0] idx_y,
  input  logic [2*DW-1:0] mem_op,
  output logic [2*DW-1:0] res,
  output logic [2:0]      dest,
  output logic            flag_h,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c
);
  localparam int WW = 2 * DW;
  localparam int HB = DW / 2;

  localparam logic [3:0] OP_ABA  = 4'd0;
  localparam logic [3:0] OP_ADCA = 4'd1;
  localparam logic [3:0] OP_ADCB = 4'd2;
  localparam logic [3:0] OP_ADDA = 4'd3;
  localparam logic [3:0] OP_ADDB = 4'd4;
  localparam logic [3:0] OP_ADDD = 4'd5;
  localparam logic [3:0] OP_ANDA = 4'd6;
  localparam logic [3:0] OP_ANDB = 4'd7;
  localparam logic [3:0] OP_ABX  = 4'd8;
  localparam logic [3:0] OP_ABY  = 4'd9;

  localparam logic [2:0] D_NONE = 3'd0;
  localparam logic [2:0] D_A    = 3'd1;
  localparam logic [2:0] D_B    = 3'd2;
  localparam logic [2:0] D_D    = 3'd3;
  localparam logic [2:0] D_X    = 3'd4;
  localparam logic [2:0] D_Y    = 3'd5;

  logic h_q, n_q, z_q, v_q, c_q;
  logic h_d, n_d, z_d, v_d, c_d;

  // byte adder operands
  logic [DW-1:0] b_lhs, b_rhs, b_and;
  logic          b_cin;
  logic [DW:0]   b_sum;
  logic [HB:0]   b_half;
  logic          b_ovf;

  always_comb begin
    b_lhs = acc_a;
    b_rhs = mem_op[DW-1:0];
    b_cin = 1'b0;
    case (op_sel)
      OP_ABA:  b_rhs = acc_b;
      OP_ADCA: b_cin = c_q;
      OP_ADCB: begin b_lhs = acc_b; b_cin = c_q; end
      OP_ADDB, OP_ANDB: b_lhs = acc_b;
      default: ;
    endcase
  end

  assign b_sum  = {1'b0, b_lhs} + {1'b0, b_rhs} + {{DW{1'b0}}, b_cin};
  assign b_half = {1'b0, b_lhs[HB-1:0]} + {1'b0, b_rhs[HB-1:0]} + {{HB{1'b0}}, b_cin};
  assign b_ovf  = (b_lhs[DW-1] == b_rhs[DW-1]) && (b_sum[DW-1] != b_lhs[DW-1]);
  assign b_and  = b_lhs & b_rhs;

  // word adder for the double accumulator
  logic [WW-1:0] w_lhs;
  logic [WW:0]   w_sum;
  logic          w_ovf;

  assign w_lhs = {acc_a, acc_b};
  assign w_sum = {1'b0, w_lhs} + {1'b0, mem_op};
  assign w_ovf = (w_lhs[WW-1] == mem_op[WW-1]) && (w_sum[WW-1] != w_lhs[WW-1]);

  // index adder
  logic [WW-1:0] i_sum;
  assign i_sum = ((op_sel == OP_ABY) ? idx_y : idx_x) + {{DW{1'b0}}, acc_b};

  always_comb begin
    res  = '0;
    dest = D_NONE;
    h_d = h_q; n_d = n_q; z_d = z_q; v_d = v_q; c_d = c_q;
    case (op_sel)
      OP_ABA, OP_ADCA, OP_ADCB, OP_ADDA, OP_ADDB: begin
        res  = {{DW{1'b0}}, b_sum[DW-1:0]};
        dest = (op_sel == OP_ADCB || op_sel == OP_ADDB) ? D_B : D_A;
        h_d  = b_half[HB];
        n_d  = b_sum[DW-1];
        z_d  = (b_sum[DW-1:0] == '0);
        v_d  = b_ovf;
        c_d  = b_sum[DW];
      end
      OP_ADDD: begin
        res  = w_sum[WW-1:0];
        dest = D_D;
        n_d  = w_sum[WW-1];
        z_d  = (w_sum[WW-1:0] == '0);
        v_d  = w_ovf;
        c_d  = w_sum[WW];
      end
      OP_ANDA, OP_ANDB: begin
        res  = {{DW{1'b0}}, b_and};
        dest = (op_sel == OP_ANDB) ? D_B : D_A;
        n_d  = b_and[DW-1];
        z_d  = (b_and == '0);
        v_d  = 1'b0;
      end
      OP_ABX, OP_ABY: begin
        res  = i_sum;
        dest = (op_sel == OP_ABY) ? D_Y : D_X;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= 1'b0; n_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0; c_q <= 1'b0;
    end else if (exec_en) begin
      h_q <= h_d; n_q <= n_d; z_q <= z_d; v_q <= v_d; c_q <= c_d;
    end
  end

  assign flag_h = h_q;
  assign flag_n = n_q;
  assign flag_z = z_q;
  assign flag_v = v_q;
  assign flag_c = c_q;
endmodule

// File: rtl/acc_alu_cc_chk.sv
module acc_alu_cc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        exec_en,
  input logic [3:0]  op_sel,
  input logic [15:0] res,
  input logic [2:0]  dest,
  input logic        flag_h,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_v,
  input logic        flag_c
);
  logic [4:0] fl;
  assign fl = {flag_h, flag_n, flag_z, flag_v, flag_c};

  p_index_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_sel == 4'd8 || op_sel == 4'd9)) |=> $stable(fl));

  p_wide_keeps_h_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && op_sel == 4'd5) |=> $stable(flag_h));

  p_and_clears_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (op_sel == 4'd6 || op_sel == 4'd7)) |=> (!flag_v && $stable(flag_c) && $stable(flag_h)));

  p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && dest >= 3'd1 && dest <= 3'd3) |=> (flag_z == ($past(res) == 16'h0)));

  p_idle_op_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd10) |-> (dest == 3'd0 && res == 16'h0));

  p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(fl));

  always_comb begin
    if (!rst_n) p_reset_clear_r10: assert (fl == 5'b0);
  end
endmodule

bind acc_alu_cc acc_alu_cc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
  .res(res), .dest(dest),
  .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
);

// File: tb/acc_alu_cc_tb_top.sv
`timescale 1ns/1ps
module acc_alu_cc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [3:0]  op_sel = 4'd15;
  logic [7:0]  acc_a = '0, acc_b = '0;
  logic [15:0] idx_x = '0, idx_y = '0, mem_op = '0;
  logic [15:0] res;
  logic [2:0]  dest;
  logic        flag_h, flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int failures = 0;
  logic [4:0] mfl = 5'b0;  // {h,n,z,v,c}

  always #2.5 clk = ~clk;

  acc_alu_cc dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .acc_a(acc_a), .acc_b(acc_b), .idx_x(idx_x), .idx_y(idx_y), .mem_op(mem_op),
    .res(res), .dest(dest),
    .flag_h(flag_h), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2: return "R2";
      4'd3, 4'd4: return "R3";
      4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] x, input logic [15:0] y, input logic [15:0] m,
                       input logic [4:0] fin, output logic [15:0] r, output logic [2:0] d,
                       output logic [4:0] fo);
    int l, rr, ci, s, hs;
    fo = fin; r = 0; d = 0;
    if (op <= 4'd4) begin
      l  = (op == 4'd2 || op == 4'd4) ? int'(b) : int'(a);
      rr = (op == 4'd0) ? int'(b) : int'(m[7:0]);
      ci = (op == 4'd1 || op == 4'd2) ? int'(fin[0]) : 0;
      s  = l + rr + ci;
      hs = (l % 16) + (rr % 16) + ci;
      r  = 16'(s % 256);
      d  = (op == 4'd2 || op == 4'd4) ? 3'd2 : 3'd1;
      fo[4] = (hs >= 16);
      fo[3] = r[7];
      fo[2] = (r == 0);
      fo[1] = ((l >= 128) == (rr >= 128)) && ((l >= 128) != r[7]);
      fo[0] = (s >= 256);
    end else if (op == 4'd5) begin
      l  = int'({a, b});
      s  = l + int'(m);
      r  = 16'(s % 65536);
      d  = 3'd3;
      fo[3] = r[15];
      fo[2] = (r == 0);
      fo[1] = ((l >= 32768) == m[15]) && ((l >= 32768) != r[15]);
      fo[0] = (s >= 65536);
    end else if (op == 4'd6 || op == 4'd7) begin
      r  = {8'h00, ((op == 4'd7) ? b : a) & m[7:0]};
      d  = (op == 4'd7) ? 3'd2 : 3'd1;
      fo[3] = r[7];
      fo[2] = (r == 0);
      fo[1] = 1'b0;
    end else if (op == 4'd8 || op == 4'd9) begin
      r = 16'((int'((op == 4'd9) ? y : x) + int'(b)) % 65536);
      d = (op == 4'd9) ? 3'd5 : 3'd4;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                        input logic [15:0] x, input logic [15:0] y, input logic [15:0] m,
                        input logic en);
    logic [15:0] er; logic [2:0] ed; logic [4:0] ef;
    @(negedge clk);
    op_sel = op; acc_a = a; acc_b = b; idx_x = x; idx_y = y; mem_op = m; exec_en = en;
    #1;
    model(op, a, b, x, y, m, mfl, er, ed, ef);
    chk(res == er, {req_of(op), " R11 result"}, 32'(res), 32'(er));
    chk(dest == ed, {req_of(op), " dest"}, 32'(dest), 32'(ed));
    @(posedge clk);
    if (en) mfl = ef;
    #1;
    chk({flag_h, flag_n, flag_z, flag_v, flag_c} == mfl,
        en ? {req_of(op), " R7 flags"} : "R9 flags held",
        32'({flag_h, flag_n, flag_z, flag_v, flag_c}), 32'(mfl));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1a2b));
    #7;
    chk({flag_h, flag_n, flag_z, flag_v, flag_c} == 5'b0, "R10 reset flags",
        32'({flag_h, flag_n, flag_z, flag_v, flag_c}), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    // directed corners
    run_op(4'd0, 8'h0F, 8'h01, 16'h0, 16'h0, 16'h0, 1'b1);     // R1 half carry
    run_op(4'd3, 8'h7F, 8'h00, 16'h0, 16'h0, 16'h0001, 1'b1);  // R3 overflow
    run_op(4'd4, 8'h00, 8'hFF, 16'h0, 16'h0, 16'h0001, 1'b1);  // R3 zero+carry
    run_op(4'd1, 8'h10, 8'h00, 16'h0, 16'h0, 16'h0020, 1'b1);  // R2 carry-in used
    run_op(4'd2, 8'h00, 8'h80, 16'h0, 16'h0, 16'h0080, 1'b1);  // R2 carry out
    run_op(4'd2, 8'h00, 8'h0E, 16'h0, 16'h0, 16'h0001, 1'b1);  // R2 half carry via cin
    run_op(4'd5, 8'h7F, 8'hFF, 16'h0, 16'h0, 16'h0001, 1'b1);  // R5 16-bit overflow, H kept
    run_op(4'd5, 8'hFF, 8'hFF, 16'h0, 16'h0, 16'h0001, 1'b1);  // R5 zero+carry
    run_op(4'd6, 8'hF0, 8'h00, 16'h0, 16'h0, 16'h000F, 1'b1);  // R6 zero, V cleared
    run_op(4'd7, 8'h00, 8'hC3, 16'h0, 16'h0, 16'h0081, 1'b1);  // R6 negative
    run_op(4'd8, 8'h00, 8'hFF, 16'hFFFF, 16'h0, 16'h0, 1'b1);  // R4 wrap
    run_op(4'd9, 8'h00, 8'h80, 16'h0, 16'h1234, 16'h0, 1'b1);  // R4 zero-extend
    run_op(4'd12, 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1); // R8 idle
    run_op(4'd0, 8'hFF, 8'hFF, 16'h0, 16'h0, 16'h0, 1'b0);     // R9 no exec
    for (int i = 0; i < 3000; i++) begin
      run_op(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
             16'($urandom), 16'($urandom), 16'($urandom),
             ($urandom_range(0, 3) != 0));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule